// File: doc/BRIEF.md
# Burst Bus Initiator

This block is the initiator side of a shared burst bus whose signals are all sampled on the rising clock edge. Address and data share one path. A local client asks for a read or write burst by giving a start address, a direction and a beat count. The block then runs the whole transaction on the bus: an address phase, an idle turnaround cycle on reads, data phases and a clean end.

Write words come in through a ready/valid port and are held in a register while they are on the bus. Read words go out through a two-entry buffer with a ready/valid port. A data beat completes only on an edge where both the initiator-ready strobe and the target-ready strobe are high. Either side can add wait states. The block holds its own strobe low when it has no write word, or when the read buffer has no room for another word.

Top module: `burst_bus_master`

## Requirements
- R1: While reset is held, `bus_frame`, `bus_irdy`, `bus_ad_oe`, `wr_ready` and `rd_valid` are low, `bus_cmd` is 0 and `req_ready` is high.
- R2: `req_ready` is high only while no transaction is running. A request with a nonzero count that is accepted on an edge gives an address phase in the next cycle. In that cycle `bus_frame` and `bus_ad_oe` are high, `bus_ad_out` carries the start address, `bus_irdy` is low and `bus_cmd` is 4'b0111 for a write or 4'b0110 for a read. In every other cycle `bus_cmd` is 0.
- R3: A beat completes on an edge only when `bus_irdy` and `bus_trdy` are both high. Each burst completes exactly the requested number of beats.
- R4: During data phases, `bus_frame` is low exactly when one beat remains and `bus_irdy` is high. `bus_frame` therefore never falls while `bus_irdy` is low.
- R5: In the cycle after the final beat, `bus_frame`, `bus_irdy` and `bus_ad_oe` are low and `req_ready` is high.
- R6: On a write, words are taken on `wr_valid && wr_ready` in order. `wr_ready` is high only while words are still owed to the burst, the bus is in the address or data phase, and no word is held or the held word completes on this edge. The held word drives `bus_ad_out` with `bus_ad_oe` high for the whole data phase and stays stable while waiting.
- R7: In the data phases of a write, `bus_irdy` is high exactly when a write word is held. With `wr_valid` low and no word held, the block inserts wait states.
- R8: On a read, the cycle after the address phase is a turnaround cycle: `bus_ad_oe` and `bus_irdy` are low and `bus_frame` stays high. `bus_ad_oe` stays low for the rest of the read.
- R9: Each read beat captures `bus_ad_in`. The captured words appear on `rd_data` in beat order. `rd_valid` is high exactly when at least one captured word has not yet been taken.
- R10: In the data phases of a read, `bus_irdy` is high exactly when at most one captured word is waiting. The two-entry buffer never overflows.
- R11: Once `bus_irdy` is high, it stays high until a beat completes.
- R12: A request with a beat count of 0 is accepted and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all signals sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 for a write burst, 0 for a read burst |
| req_addr | input | DW | Start address |
| req_beats | input | CW | Number of data beats |
| wr_valid | input | 1 | Write word available |
| wr_ready | output | 1 | Block takes the write word on this edge |
| wr_data | input | DW | Write word |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Client takes the read word on this edge |
| rd_data | output | DW | Read word |
| bus_frame | output | 1 | Transaction frame strobe (active high) |
| bus_irdy | output | 1 | Initiator ready strobe (active high) |
| bus_trdy | input | 1 | Target ready strobe (active high) |
| bus_cmd | output | 4 | Command field, valid in the address phase |
| bus_ad_out | output | DW | Multiplexed address/data driven by the block |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_ad_in | input | DW | Multiplexed address/data from the target |

## Verification
The hardest state to reach is a read data phase where two captured words are waiting, the initiator strobe must be low, and the frame strobe is still high for the final beat. The same applies to a write whose last beat keeps waiting with the frame already low. The stimulus drives the target strobe, the write source and the read sink from independent per-cycle probabilities. Some bursts starve the read sink to a small rate while the target stays fast, and others make the target slow while the write source is bursty. A reference model follows the outstanding counts and predicts both strobes in every cycle, so these rare overlaps are checked whenever they occur.

// File: rtl/burst_bus_master.sv
`timescale 1ns/1ps
module burst_bus_master #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [CW-1:0] req_beats,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          bus_frame,
  output logic          bus_irdy,
  input  logic          bus_trdy,
  output logic [3:0]    bus_cmd,
  output logic [DW-1:0] bus_ad_out,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_in
);
  localparam logic [3:0] CMD_RD = 4'b0110;
  localparam logic [3:0] CMD_WR = 4'b0111;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_TURN, S_DATA} st_t;

  st_t           st;
  logic          wr_q, irdy_q;
  logic [DW-1:0] addr_q, dreg;
  logic [CW-1:0] rem, to_load;
  logic [DW-1:0] fifo [2];
  logic          rp, wp;
  logic [1:0]    cnt, cnt_n;
  logic          beat, last, push, pop, in_xfer;

  assign beat    = irdy_q & bus_trdy;
  assign last    = beat && (rem == CW'(1));
  assign in_xfer = (st == S_ADDR) || (st == S_DATA);
  assign push    = beat & ~wr_q;
  assign pop     = rd_valid & rd_ready;
  assign cnt_n   = cnt + {1'b0, push} - {1'b0, pop};

  assign req_ready = (st == S_IDLE);
  assign wr_ready  = wr_q && in_xfer && (to_load != '0) && (!irdy_q || beat);
  assign rd_valid  = (cnt != 2'd0);
  assign rd_data   = fifo[rp];

  assign bus_irdy   = irdy_q;
  assign bus_frame  = (st == S_ADDR) ||
                      (((st == S_TURN) || (st == S_DATA)) && ((rem > CW'(1)) || !irdy_q));
  assign bus_cmd    = (st == S_ADDR) ? (wr_q ? CMD_WR : CMD_RD) : 4'b0000;
  assign bus_ad_oe  = (st == S_ADDR) || ((st == S_DATA) && wr_q);
  assign bus_ad_out = (st == S_ADDR) ? addr_q : (((st == S_DATA) && wr_q) ? dreg : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wr_q    <= 1'b0;
      irdy_q  <= 1'b0;
      addr_q  <= '0;
      dreg    <= '0;
      rem     <= '0;
      to_load <= '0;
      rp      <= 1'b0;
      wp      <= 1'b0;
      cnt     <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (req_valid && req_beats != '0) begin
          st      <= S_ADDR;
          wr_q    <= req_write;
          addr_q  <= req_addr;
          rem     <= req_beats;
          to_load <= req_beats;
        end
        S_ADDR: st <= wr_q ? S_DATA : S_TURN;
        S_TURN: st <= S_DATA;
        S_DATA: if (last) st <= S_IDLE;
      endcase

      if (beat) rem <= rem - CW'(1);

      if (wr_q) begin
        if (wr_ready && wr_valid) begin
          dreg    <= wr_data;
          irdy_q  <= 1'b1;
          to_load <= to_load - CW'(1);
        end else if (beat) begin
          irdy_q <= 1'b0;
        end
      end else begin
        irdy_q <= ((st == S_TURN) || (st == S_DATA)) && !last && (cnt_n <= 2'd1);
      end

      if (push) begin
        fifo[wp] <= bus_ad_in;
        wp       <= ~wp;
      end
      if (pop) rp <= ~rp;
      cnt <= cnt_n;
    end
  end

  AST_IRDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_irdy && !bus_trdy |=> bus_irdy); // R11
  AST_LAST_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_irdy && bus_trdy && !bus_frame |=> !bus_irdy && !bus_frame && !bus_ad_oe && req_ready); // R5
  AST_FRAME_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_frame) |-> bus_irdy); // R4
  AST_READ_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd == CMD_RD |=> !bus_ad_oe && !bus_irdy && bus_frame); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt != 2'd2); // R10
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_irdy && !bus_trdy && bus_ad_oe |=> $stable(bus_ad_out)); // R6
  AST_CMD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd != 4'b0000 |=> bus_cmd == 4'b0000 && !req_ready); // R2
  AST_BEAT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_irdy); // R3
endmodule

// File: tb/sim_burst_bus_master.sv
`timescale 1ns/1ps
module sim_burst_bus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_beats = '0;
  logic        wr_valid = 1'b0, rd_ready = 1'b0, bus_trdy = 1'b0;
  logic [31:0] wr_data = '0, bus_ad_in = '0;
  logic        req_ready, wr_ready, rd_valid, bus_frame, bus_irdy, bus_ad_oe;
  logic [31:0] rd_data, bus_ad_out;
  logic [3:0]  bus_cmd;

  always #2 clk = ~clk;

  burst_bus_master #(.DW(32), .CW(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_beats(req_beats),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .bus_frame(bus_frame), .bus_irdy(bus_irdy), .bus_trdy(bus_trdy),
    .bus_cmd(bus_cmd), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int p_trdy = 100, p_wr = 100, p_rd = 100;
  int wr_seq = 0;
  bit m_acc_pend = 0, m_acc_wr = 0, m_wr = 0, m_post = 0, prev_wait = 0;
  logic [31:0] m_acc_addr = '0;
  int m_acc_beats = 0, m_phase = 0, m_left = 0, held = 0, handed = 0, beats_tot = 0;
  int m_done = 0, pending = 0, zero_win = 0;
  logic [31:0] wq[$];
  logic [31:0] rq[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #1;
    bus_trdy  = int'($urandom % 100) < p_trdy;
    rd_ready  = int'($urandom % 100) < p_rd;
    wr_valid  = int'($urandom % 100) < p_wr;
    wr_data   = 32'h1000_0000 ^ (32'(wr_seq) * 32'h0009_E37B);
    bus_ad_in = $urandom;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit beat, exp_wr_ready;
    if (m_acc_pend) begin
      m_acc_pend = 0;
      if (m_acc_beats == 0) zero_win = 3;
      else begin
        m_phase = 1; m_wr = m_acc_wr; m_left = m_acc_beats;
        beats_tot = m_acc_beats; handed = 0; held = 0; m_done = 0;
      end
    end
    case (m_phase)
      0: begin
        string t;
        t = zero_win > 0 ? "R12" : "R5";
        chk(t, bus_frame, 0); chk(t, bus_irdy, 0); chk(t, bus_ad_oe, 0);
        chk(t, req_ready, 1); chk("R2", bus_cmd, 0);
        if (zero_win > 0) zero_win--;
        m_post = 0;
      end
      1: begin
        chk("R2", bus_frame, 1); chk("R2", bus_ad_oe, 1); chk("R2", bus_ad_out, m_acc_addr);
        chk("R2", bus_cmd, m_wr ? 4'b0111 : 4'b0110); chk("R2", bus_irdy, 0); chk("R2", req_ready, 0);
      end
      2: begin
        chk("R8", bus_ad_oe, 0); chk("R8", bus_irdy, 0); chk("R8", bus_frame, 1); chk("R2", bus_cmd, 0);
      end
      default: begin
        chk("R4", bus_frame, (m_left > 1 || !bus_irdy) ? 1 : 0);
        chk("R2", bus_cmd, 0); chk("R2", req_ready, 0);
        if (m_wr) begin
          chk("R6", bus_ad_oe, 1);
          chk("R7", bus_irdy, held > 0 ? 1 : 0);
          if (bus_irdy && wq.size() > 0) chk("R6", bus_ad_out, wq[0]);
        end else begin
          chk("R8", bus_ad_oe, 0);
          chk("R10", bus_irdy, pending <= 1 ? 1 : 0);
        end
      end
    endcase
    if (prev_wait) chk("R11", bus_irdy, 1);
    beat = bus_irdy && bus_trdy;
    exp_wr_ready = m_wr && (m_phase == 1 || m_phase == 3) && handed < beats_tot && (held == 0 || beat);
    chk("R6", wr_ready, exp_wr_ready);
    chk("R9", rd_valid, pending > 0 ? 1 : 0);
    if (rd_valid && rd_ready) begin
      if (rq.size() > 0) chk("R9", rd_data, rq.pop_front());
      pending--;
    end
    if (wr_valid && wr_ready) begin
      wq.push_back(wr_data); held++; handed++; wr_seq++;
    end
    if (beat) begin
      if (m_phase != 3) chk("R3", m_phase, 3);
      if (m_wr) begin void'(wq.pop_front()); held--; end
      else begin rq.push_back(bus_ad_in); pending++; end
      m_left--; m_done++;
    end
    prev_wait = bus_irdy && !bus_trdy;
    if (m_phase == 1) m_phase = m_wr ? 3 : 2;
    else if (m_phase == 2) m_phase = 3;
    else if (m_phase == 3 && beat && m_left == 0) begin m_phase = 0; m_post = 1; end
    if (req_valid && req_ready) begin
      m_acc_pend = 1; m_acc_wr = req_write; m_acc_addr = req_addr; m_acc_beats = int'(req_beats);
    end
  end

  task automatic burst(bit w, logic [31:0] a, int n, int pt, int pw, int pr);
    p_trdy = pt; p_wr = pw; p_rd = pr;
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_addr = a; req_beats = 8'(n);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
    do @(negedge clk); while (m_phase != 0 || m_acc_pend || pending != 0);
    repeat (3) @(negedge clk);
    chk("R3", m_done, (n == 0) ? m_done : n);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", bus_frame, 0); chk("R1", bus_irdy, 0); chk("R1", bus_ad_oe, 0);
    chk("R1", wr_ready, 0); chk("R1", rd_valid, 0); chk("R1", bus_cmd, 0); chk("R1", req_ready, 1);
    @(posedge clk); #1 rst_n = 1;
    burst(1, 32'h0000_1000, 4, 100, 100, 100);
    burst(1, 32'h0000_2000, 6, 50, 60, 100);
    burst(0, 32'h0000_3000, 4, 100, 100, 100);
    burst(0, 32'h0000_4000, 8, 90, 100, 25);
    burst(1, 32'h0000_5000, 1, 30, 40, 100);
    burst(0, 32'h0000_6000, 1, 100, 100, 100);
    burst(1, 32'h0000_7000, 0, 100, 100, 100);
    burst(0, 32'h0000_8000, 12, 100, 100, 10);
    burst(1, 32'h0000_9000, 16, 20, 20, 100);
    for (int i = 0; i < 24; i++)
      burst(1'($urandom % 2), $urandom, int'($urandom % 17), 20 + int'($urandom % 81),
            20 + int'($urandom % 81), 15 + int'($urandom % 86));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule